// File: doc/BRIEF.md
# Protected Configuration Register Bank

This block keeps a small window of byte-wide configuration registers inside a larger byte-addressed space, and it judges every write aimed at the rest of that space. Seven control registers and a read-only status byte sit in a sixteen-address window. The remaining addresses of the window are unused. Any address outside the window belongs to a memory array. The block does not store that array. It only forwards or refuses each write that targets it.

Six of the control registers have nonvolatile backing copies, which a simple array with a write strobe models here. At power-up, which is the reset input, those six registers reload from their backing copies, and the seventh register clears. Two of the backed registers always write through to their copies. The other four write through only when a mode bit in the first control register is set. Two lock bits in that first register select which array ranges refuse writes. An active-low protect input refuses every array write, whatever the lock bits hold.

Top module: `cfg_lock_bank`

## Requirements
- R1: Control registers 0 to 6 sit at addresses 080h to 086h. A write there is accepted, and reading the same address returns the written byte in the cycle after the write edge.
- R2: A read of 087h returns the `stat_in` byte, and a read of 088h to 08Fh returns 00h. Any write to 087h to 08Fh is rejected and changes nothing.
- R3: While `rst_n` is low, control registers 0 to 5 load their backing copies and register 6 loads 00h. While `nv_rst_n` is low, every backing copy becomes 00h.
- R4: Control register 0 bits [1:0] are the lock code. Code 0 locks nothing. Code 1 locks 000h-07Fh. Code 2 locks 000h-07Fh and 090h-0CFh. Code 3 locks 000h-07Fh and 090h-10Fh. Addresses 110h and above are never locked.
- R5: A write to a locked array address is rejected, and `arr_we` stays low.
- R6: While `wp_n` is low, every write to an array address is rejected, whatever the lock code.
- R7: An accepted array write raises `arr_we` for one cycle, one clock after the request, with `arr_addr` and `arr_wdata` equal to the request.
- R8: Control register 0 bit 2 is the persist mode. When it is 0, writes to registers 1 to 4 are lost at the next reset. When it is 1, those writes survive a reset.
- R9: Writes to registers 0 and 5 always survive a reset. Writes to register 6 never survive a reset.
- R10: Control register 0 bit 7 is reserved. It always reads 0, in the register and in its backing copy, whatever value is written to it.
- R11: Each write request produces exactly one of `wr_accept` or `wr_reject`, as a one-cycle pulse one clock later. No pulse appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, synchronous; reloads the volatile registers |
| nv_rst_n | input | 1 | Erases the backing store to a new-device state, active low |
| wp_n | input | 1 | Write protect for the array, active low |
| bus_we | input | 1 | Write request strobe |
| bus_addr | input | 9 | Request address |
| bus_wdata | input | 8 | Write data |
| stat_in | input | 8 | Live status byte, read at 087h |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| wr_accept | output | 1 | One-cycle pulse when a write is taken |
| wr_reject | output | 1 | One-cycle pulse when a write is refused |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 9 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
A wrong lock code or a missed protect check shows up one clock after the request, as an inverted accept/reject pair or as a stray `arr_we`. A register that holds the wrong byte appears at once on `bus_rdata` when its address is presented. A wrong write-through decision stays hidden until the next reset, so the bench power-cycles the block after each persist-mode case and compares the reloaded bytes. The bench's reference model follows every cycle, so any difference is reported within one clock of the edge that caused it.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_RSV  = 2'd2,
    SEL_ARR  = 2'd3
  } sel_e;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_bank_pkg::*;
#(
  parameter int AW = 9,
  parameter int NCTL = 7,
  parameter int WIN = 16,
  parameter logic [AW-1:0] BASE = 9'h080,
  localparam int IW = $clog2(NCTL)
) (
  input  logic [AW-1:0] addr,
  output sel_e          sel,
  output logic [IW-1:0] idx
);
  localparam logic [AW-1:0] CTL_END = BASE + AW'(NCTL - 1);
  localparam logic [AW-1:0] STAT_A  = BASE + AW'(NCTL);
  localparam logic [AW-1:0] WIN_END = BASE + AW'(WIN - 1);

  always_comb begin
    idx = IW'(addr - BASE);
    if (addr >= BASE && addr <= CTL_END)       sel = SEL_CTL;
    else if (addr == STAT_A)                   sel = SEL_STAT;
    else if (addr > STAT_A && addr <= WIN_END) sel = SEL_RSV;
    else                                       sel = SEL_ARR;
  end
endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard #(
  parameter int AW = 9,
  parameter logic [AW-1:0] LO_BASE = 9'h000,
  parameter logic [AW-1:0] LO_END  = 9'h07F,
  parameter logic [AW-1:0] UP_BASE = 9'h090,
  parameter logic [AW-1:0] MID_END = 9'h0CF,
  parameter logic [AW-1:0] TOP_END = 9'h10F
) (
  input  logic [1:0]    lock_code,
  input  logic [AW-1:0] addr,
  output logic          locked
);
  function automatic logic in_span(input logic [AW-1:0] a,
                                   input logic [AW-1:0] lo,
                                   input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic low_hit, mid_hit, top_hit;

  always_comb begin
    low_hit = in_span(addr, LO_BASE, LO_END);
    mid_hit = in_span(addr, UP_BASE, MID_END);
    top_hit = in_span(addr, UP_BASE, TOP_END);
    unique case (lock_code)
      2'd0: locked = 1'b0;
      2'd1: locked = low_hit;
      2'd2: locked = low_hit | mid_hit;
      default: locked = low_hit | top_hit;
    endcase
  end
endmodule

// File: rtl/cfg_nv_store.sv
module cfg_nv_store #(
  parameter int DW = 8,
  parameter int NNV = 6,
  parameter int IW = 3
) (
  input  logic                     clk,
  input  logic                     nv_rst_n,
  input  logic                     wr,
  input  logic [IW-1:0]            widx,
  input  logic [DW-1:0]            wdata,
  output logic [NNV-1:0][DW-1:0]   image
);
  for (genvar g = 0; g < NNV; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!nv_rst_n)                      image[g] <= '0;
      else if (wr && widx == IW'(g))      image[g] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_ctl_regs.sv
module cfg_ctl_regs #(
  parameter int DW = 8,
  parameter int NCTL = 7,
  parameter int NNV = 6,
  parameter int IW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NNV-1:0][DW-1:0]   nv_image,
  input  logic                     wr,
  input  logic [IW-1:0]            widx,
  input  logic [DW-1:0]            wdata,
  output logic [NCTL-1:0][DW-1:0]  ctl_q
);
  for (genvar g = 0; g < NCTL; g++) begin : g_reg
    if (g < NNV) begin : g_backed
      always_ff @(posedge clk) begin
        if (!rst_n)                       ctl_q[g] <= nv_image[g];
        else if (wr && widx == IW'(g))    ctl_q[g] <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)                       ctl_q[g] <= '0;
        else if (wr && widx == IW'(g))    ctl_q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_bank_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int NCTL = 7,
  parameter int NNV = 6,
  parameter int WIN = 16,
  parameter logic [AW-1:0] BASE = 9'h080,
  parameter int LOCK_LSB = 0,
  parameter int MODE_BIT = 2,
  parameter logic [DW-1:0] CR0_RSV = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_rst_n,
  input  logic          wp_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] stat_in,
  output logic [DW-1:0] bus_rdata,
  output logic          wr_accept,
  output logic          wr_reject,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata
);
  localparam int IW = $clog2(NCTL);
  localparam logic [IW-1:0] LAST_NV = IW'(NNV - 1);

  sel_e                     sel;
  logic [IW-1:0]            idx;
  logic                     locked;
  logic [1:0]               lock_bits;
  logic                     vol_mode;
  logic                     reg_wr;
  logic                     persist;
  logic                     nv_wr;
  logic                     arr_ok;
  logic                     accept_d;
  logic [DW-1:0]            wdata_clean;
  logic [NNV-1:0][DW-1:0]   nv_image;
  logic [NCTL-1:0][DW-1:0]  ctl_q;

  cfg_addr_dec #(.AW(AW), .NCTL(NCTL), .WIN(WIN), .BASE(BASE)) u_dec (
    .addr(bus_addr), .sel(sel), .idx(idx)
  );

  assign lock_bits = ctl_q[0][LOCK_LSB +: 2];
  assign vol_mode  = ctl_q[0][MODE_BIT];

  cfg_lock_guard #(.AW(AW)) u_guard (
    .lock_code(lock_bits), .addr(bus_addr), .locked(locked)
  );

  always_comb begin
    wdata_clean = (idx == '0) ? (bus_wdata & ~CR0_RSV) : bus_wdata;
    reg_wr      = rst_n && bus_we && (sel == SEL_CTL);
    persist     = (idx == '0) || (idx == LAST_NV) ||
                  ((idx < LAST_NV) && vol_mode);
    nv_wr       = reg_wr && persist;
    arr_ok      = bus_we && (sel == SEL_ARR) && wp_n && !locked;
    accept_d    = reg_wr || arr_ok;
  end

  cfg_nv_store #(.DW(DW), .NNV(NNV), .IW(IW)) u_nv (
    .clk(clk), .nv_rst_n(nv_rst_n), .wr(nv_wr), .widx(idx),
    .wdata(wdata_clean), .image(nv_image)
  );

  cfg_ctl_regs #(.DW(DW), .NCTL(NCTL), .NNV(NNV), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .nv_image(nv_image), .wr(reg_wr),
    .widx(idx), .wdata(wdata_clean), .ctl_q(ctl_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_accept <= 1'b0;
      wr_reject <= 1'b0;
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      wr_accept <= accept_d;
      wr_reject <= bus_we && !accept_d;
      arr_we    <= arr_ok;
      if (arr_ok) begin
        arr_addr  <= bus_addr;
        arr_wdata <= bus_wdata;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTL:  bus_rdata = ctl_q[idx];
      SEL_STAT: bus_rdata = stat_in;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_lock_bank_chk.sv
module cfg_lock_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 3,
  parameter int NNV = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_n,
  input logic          bus_we,
  input logic [1:0]    sel,
  input logic [IW-1:0] idx,
  input logic          locked,
  input logic [1:0]    lock_bits,
  input logic          vol_mode,
  input logic          nv_wr,
  input logic [DW-1:0] ctl_last,
  input logic          wr_accept,
  input logic          wr_reject,
  input logic          arr_we
);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_accept && wr_reject));
  p_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (wr_accept || wr_reject));
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> !(wr_accept || wr_reject));
  p_wp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_ARR && !wp_n) |=> (wr_reject && !arr_we));
  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_ARR && locked) |=> (wr_reject && !arr_we));
  p_nolock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (lock_bits != 2'd0));
  p_arrack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> wr_accept);
  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (sel == SEL_STAT || sel == SEL_RSV)) |=> wr_reject);
  p_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr && idx != '0 && idx != IW'(NNV - 1)) |-> vol_mode);
  p_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |-> (idx < IW'(NNV)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctl_last == '0));
endmodule

bind cfg_lock_bank cfg_lock_bank_chk #(.DW(DW), .IW(IW), .NNV(NNV)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .bus_we(bus_we), .sel(sel),
  .idx(idx), .locked(locked), .lock_bits(lock_bits), .vol_mode(vol_mode),
  .nv_wr(nv_wr), .ctl_last(ctl_q[NCTL-1]), .wr_accept(wr_accept),
  .wr_reject(wr_reject), .arr_we(arr_we)
);

// File: tb/cfg_lock_bank_bench.sv
module cfg_lock_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nv_rst_n = 1'b0;
  logic       wp_n = 1'b1;
  logic       bus_we = 1'b0;
  logic [8:0] bus_addr = 9'h000;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] stat_in = 8'h3C;
  logic [7:0] bus_rdata;
  logic       wr_accept, wr_reject, arr_we;
  logic [8:0] arr_addr;
  logic [7:0] arr_wdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int vol[7];
  int nv[6];

  always #10 clk = ~clk;

  cfg_lock_bank u_cfg_lock_bank (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .wp_n(wp_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stat_in(stat_in), .bus_rdata(bus_rdata), .wr_accept(wr_accept),
    .wr_reject(wr_reject), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_locked(input int code, input int a);
    if (a < 128) return code != 0;
    if (a >= 144 && a < 208) return code >= 2;
    if (a >= 208 && a < 272) return code == 3;
    return 0;
  endfunction

  function automatic int ref_read(input int a);
    if (a >= 128 && a < 135) return vol[a - 128];
    if (a == 135) return int'(stat_in);
    return 0;
  endfunction

  // reference model, advanced once per clock and compared to the outputs
  always @(posedge clk) begin
    int a, d, e_acc, e_rej, e_arr, i;
    string tag;
    a = int'(bus_addr); d = int'(bus_wdata);
    e_acc = 0; e_rej = 0; e_arr = 0; tag = "R11";
    if (!rst_n) begin
      for (int k = 0; k < 6; k++) vol[k] = nv[k];
      vol[6] = 0;
      tag = "R3";
    end else if (bus_we) begin
      if (a >= 128 && a < 135) begin
        i = a - 128;
        if (i == 0) d = d % 128;
        if (i == 0 || i == 5 || (i >= 1 && i <= 4 && (vol[0] / 4) % 2 == 1))
          nv[i] = d;
        vol[i] = d;
        e_acc = 1; tag = "R1";
      end else if (a >= 135 && a < 144) begin
        e_rej = 1; tag = "R2";
      end else if (!wp_n) begin
        e_rej = 1; tag = "R6";
      end else if (ref_locked(vol[0] % 4, a)) begin
        e_rej = 1; tag = "R5";
      end else begin
        e_acc = 1; e_arr = 1; tag = "R7";
      end
    end
    if (!nv_rst_n) for (int k = 0; k < 6; k++) nv[k] = 0;
    #5;
    chk(wr_accept == e_acc[0], {tag, " accept"}, wr_accept, e_acc);
    chk(wr_reject == e_rej[0], {tag, " reject"}, wr_reject, e_rej);
    chk(arr_we == e_arr[0], {tag, " arr_we"}, arr_we, e_arr);
    if (e_arr == 1) begin
      chk(int'(arr_addr) == a, "R7 arr_addr", arr_addr, a);
      chk(int'(arr_wdata) == int'(bus_wdata), "R7 arr_wdata", arr_wdata, bus_wdata);
    end
    chk(int'(bus_rdata) == ref_read(int'(bus_addr)), "R1 readback", bus_rdata,
        ref_read(int'(bus_addr)));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 9'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_expect(input int a, input int d, input bit acc, input string tag);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 9'(a); bus_wdata = 8'(d);
    @(negedge clk);
    chk(wr_accept == acc, tag, wr_accept, acc);
    bus_we = 1'b0;
  endtask

  task automatic rd_expect(input int a, input int exp, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 9'(a);
    #2;
    chk(int'(bus_rdata) == exp, tag, bus_rdata, exp);
  endtask

  task automatic power_cycle();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int k = 0; k < 7; k++) vol[k] = 0;
    for (int k = 0; k < 6; k++) nv[k] = 0;
    repeat (3) @(negedge clk);
    nv_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 7; k++) rd_expect(128 + k, 0, "R3 fresh reset");

    wr_expect(9'h080, 8'h80, 1'b1, "R10 write");
    rd_expect(9'h080, 8'h00, "R10 reserved bit reads 0");
    wr_expect(9'h000, 8'h11, 1'b1, "R4 code0 000h");
    wr_expect(9'h10F, 8'h12, 1'b1, "R4 code0 10Fh");

    wr(9'h080, 8'h01);
    wr_expect(9'h07F, 8'h13, 1'b0, "R5 code1 07Fh");
    wr_expect(9'h090, 8'h14, 1'b1, "R4 code1 090h");
    wr(9'h080, 8'h02);
    wr_expect(9'h0CF, 8'h15, 1'b0, "R5 code2 0CFh");
    wr_expect(9'h0D0, 8'h16, 1'b1, "R4 code2 0D0h");
    wr(9'h080, 8'h03);
    wr_expect(9'h10F, 8'h17, 1'b0, "R5 code3 10Fh");
    wr_expect(9'h110, 8'h18, 1'b1, "R4 code3 110h");
    wr_expect(9'h083, 8'h5A, 1'b1, "R1 reg write under lock");
    rd_expect(9'h083, 8'h5A, "R1 readback");

    @(negedge clk); wp_n = 1'b0;
    wr_expect(9'h110, 8'h19, 1'b0, "R6 protect 110h");
    wr(9'h080, 8'h00);
    wr_expect(9'h1FF, 8'h1A, 1'b0, "R6 protect code0");
    @(negedge clk); wp_n = 1'b1;

    rd_expect(9'h087, 8'h3C, "R2 status read");
    wr_expect(9'h087, 8'hFF, 1'b0, "R2 status write");
    rd_expect(9'h087, 8'h3C, "R2 status unchanged");
    wr_expect(9'h08A, 8'hFF, 1'b0, "R2 unused write");
    rd_expect(9'h08A, 8'h00, "R2 unused read");

    wr(9'h081, 8'h11);
    wr(9'h086, 8'hA5);
    wr(9'h085, 8'h55);
    power_cycle();
    rd_expect(9'h081, 8'h00, "R8 mode0 lost");
    rd_expect(9'h083, 8'h00, "R8 mode0 lost reg3");
    rd_expect(9'h086, 8'h00, "R9 reg6 cleared");
    rd_expect(9'h085, 8'h55, "R9 reg5 kept");

    wr(9'h080, 8'h84);
    wr(9'h082, 8'h22);
    wr(9'h084, 8'h44);
    power_cycle();
    rd_expect(9'h080, 8'h04, "R10 reserved bit not stored");
    rd_expect(9'h082, 8'h22, "R8 mode1 kept");
    rd_expect(9'h084, 8'h44, "R8 mode1 kept reg4");

    @(negedge clk); nv_rst_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); nv_rst_n = 1'b1;
    power_cycle();
    rd_expect(9'h080, 8'h00, "R3 erased reg0");
    rd_expect(9'h085, 8'h00, "R3 erased reg5");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule